// File: doc/BRIEF.md
# SPI Slave Receiver with Preset First Reply

This block is the target side of a four-signal serial link. An external controller drives the serial clock, the active-low select and the data line. The block samples all of these in its own system clock domain. Each byte that comes in is stored in an eight-entry byte queue, and the local side drains that queue. When the select line goes active, the block loads a programmable preset byte into its transmit shifter, so the controller always reads that byte first. The preset register comes out of reset as 0x10.

The byte queue is shared between the two directions. In receive direction, incoming bytes are pushed into it and the local side pops them. In transmit direction, the local side pushes reply bytes, and the shifter pops one at each byte boundary after the preset byte. An optional command mode flags the first byte of each selection as a command. A separate first-byte flag, with its own enable and a write-one clear, drives an interrupt. The data output is driven only while its enable is set. A shared-pin mode takes receive data from the same pin that carries replies.

Top module: `spi_preset_slave`

## Requirements
- R1: After reset, `fifo_count` is 0, `miso_oe`, `st_selected`, `st_cmd_rcvd`, `st_preset_load`, `first_if` and `irq` are 0, `miso_o` is 1, and the preset value is 0x10.
- R2: While the block is enabled, a falling `cs_n_i` loads the preset value into the transmit shifter, and `miso_o` then gives its bits MSB first. Writing the preset (`preset_we`) affects only selections that begin after the write.
- R3: Received bits are sampled on rising SCK, MSB first. When `fifo_dir_out`=0, each complete byte is pushed into the queue (dropped if 8 are held), `host_rdata` shows the oldest byte, and `host_pop` removes it. `host_push` is ignored in this direction.
- R4: After the preset byte, each following reply byte is popped from the queue when `fifo_dir_out`=1 and the queue is not empty. Otherwise the reply byte is 0xFF. `host_pop` is ignored while `fifo_dir_out`=1.
- R5: The shifter advances on a falling SCK only after a rising SCK has been seen since the last advance. This makes clock-idle-low (mode 0) and clock-idle-high (mode 3) controllers both read the preset MSB correctly.
- R6: Raising `cs_n_i` in the middle of a byte discards the partial byte and clears the bit position. The next selection starts again with the preset byte.
- R7: `st_selected` rises on the third rising `clk` edge after `cs_n_i` falls and stays high until deselect. `st_preset_load` is high for exactly that one cycle.
- R8: With `cmd_mode`=1, completing the first byte of a selection sets `st_cmd_rcvd`. The next selection clears it. It is never set while `cmd_mode`=0.
- R9: Completing the first byte of each selection sets `first_if`. A pulse on `first_if_clr` clears it, and a new set in the same cycle wins. `irq` = `first_if` AND `first_ie`.
- R10: `miso_oe` = `slave_en` AND `miso_oe_en` AND `st_selected` AND (NOT `two_wire` OR `fifo_dir_out`).
- R11: With `two_wire`=1, receive data is taken from `miso_i` instead of `mosi_i`.
- R12: With `slave_en`=0, select edges are ignored: `st_selected` stays 0 and no byte is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | Enables the slave engine |
| cmd_mode | input | 1 | Treat the first byte as a command |
| two_wire | input | 1 | Shared data pin mode |
| miso_oe_en | input | 1 | Permits driving the data output |
| fifo_dir_out | input | 1 | Queue direction: 1 = replies, 0 = received bytes |
| first_ie | input | 1 | First-byte interrupt enable |
| preset_we | input | 1 | Preset register write strobe |
| preset_wdata | input | 8 | Preset write value |
| host_push | input | 1 | Local push into the queue |
| host_wdata | input | 8 | Local push data |
| host_pop | input | 1 | Local pop from the queue |
| host_rdata | output | 8 | Oldest queued byte |
| fifo_count | output | 4 | Queue occupancy |
| first_if_clr | input | 1 | Write-one clear of the first-byte flag |
| sck_i | input | 1 | Serial clock from the controller |
| cs_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Controller data in |
| miso_i | input | 1 | Shared pin input |
| miso_o | output | 1 | Reply data |
| miso_oe | output | 1 | Reply data output enable |
| st_selected | output | 1 | Select is active |
| st_cmd_rcvd | output | 1 | Command byte received |
| st_preset_load | output | 1 | Preset byte being loaded |
| first_if | output | 1 | First-byte flag |
| irq | output | 1 | First-byte interrupt |

## Verification
Every pin event takes effect on the third rising `clk` edge after it. Two edges go to the synchronizer and one to the registered engine. Local strobes act on the next edge. The bench drives all inputs on falling `clk` edges. A behavioural reference, built on queues, steps on each rising edge, and the bench compares it with the ports a quarter period later. The serial half-period is four clocks, so the bench reads `miso_o` after its three-cycle update has settled. Directed checks pin down the exact select-to-status cycle and the literal bytes seen on both sides.

// File: rtl/spis_pkg.sv
package spis_pkg;
    typedef struct packed {
        logic rise;
        logic fall;
        logic sel;
        logic desel;
    } spis_evt_t;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = d;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{meta: RST_VAL, stable: RST_VAL};
        else        s_q <= s_d;
    end

    assign q = s_q.stable;
endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
    parameter int  DEPTH = 8,
    parameter int  W     = 8,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d     = f_q;
        do_push = push && (f_q.cnt < CW'(DEPTH));
        do_pop  = pop && (f_q.cnt != '0);
        if (do_push) begin
            f_d.mem[f_q.wr] = push_data;
            f_d.wr          = bump(f_q.wr);
        end
        if (do_pop) f_d.rd = bump(f_q.rd);
        f_d.cnt = f_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head  = f_q.mem[f_q.rd];
    assign count = f_q.cnt;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(DEPTH));
    p_pop_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && f_q.cnt != '0 && !push) |=> (f_q.cnt == $past(f_q.cnt) - 1'b1));
endmodule

// File: rtl/spi_preset_slave.sv
module spi_preset_slave #(
    parameter int          DATA_W     = 8,
    parameter int          FIFO_DEPTH = 8,
    parameter logic [7:0]  PRESET_RST = 8'h10,
    localparam int         BCW        = $clog2(DATA_W),
    localparam int         CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_en,
    input  logic              cmd_mode,
    input  logic              two_wire,
    input  logic              miso_oe_en,
    input  logic              fifo_dir_out,
    input  logic              first_ie,
    input  logic              preset_we,
    input  logic [DATA_W-1:0] preset_wdata,
    input  logic              host_push,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_pop,
    output logic [DATA_W-1:0] host_rdata,
    output logic [CW-1:0]     fifo_count,
    input  logic              first_if_clr,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              st_selected,
    output logic              st_cmd_rcvd,
    output logic              st_preset_load,
    output logic              first_if,
    output logic              irq
);
    import spis_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] preset;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-2:0] rx;
        logic [BCW-1:0]    cnt;
        logic              rise_seen;
        logic              first_pend;
        logic              sel;
        logic              cmd;
        logic              load;
        logic              fif;
        logic              sck_p;
        logic              cs_p;
    } eng_t;

    eng_t              e_d, e_q;
    spis_evt_t         ev;
    logic              cs_s, sck_s, din_s;
    logic [DATA_W-1:0] rx_byte, f_head, f_pdata;
    logic [CW-1:0]     f_cnt;
    logic              byte_done, first_done, shift_pop, f_push, f_pop;

    spis_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n_i, sck_i, two_wire ? miso_i : mosi_i}),
        .q     ({cs_s, sck_s, din_s})
    );

    always_comb begin
        ev.rise  = sck_s & ~e_q.sck_p;
        ev.fall  = ~sck_s & e_q.sck_p;
        ev.sel   = ~cs_s & e_q.cs_p;
        ev.desel = cs_s & ~e_q.cs_p;
    end

    always_comb begin
        e_d        = e_q;
        byte_done  = 1'b0;
        first_done = 1'b0;
        shift_pop  = 1'b0;
        rx_byte    = {e_q.rx, din_s};
        e_d.load   = 1'b0;
        e_d.sck_p  = sck_s;
        e_d.cs_p   = cs_s;
        if (preset_we) e_d.preset = preset_wdata;

        if (!slave_en || ev.desel) begin
            e_d.sel       = 1'b0;
            e_d.cnt       = '0;
            e_d.rise_seen = 1'b0;
        end else if (ev.sel) begin
            e_d.sel        = 1'b1;
            e_d.tx         = e_q.preset;
            e_d.cnt        = '0;
            e_d.rise_seen  = 1'b0;
            e_d.first_pend = 1'b1;
            e_d.load       = 1'b1;
            e_d.cmd        = 1'b0;
        end else if (e_q.sel) begin
            if (ev.rise) begin
                e_d.rx        = rx_byte[DATA_W-2:0];
                e_d.cnt       = e_q.cnt + 1'b1;
                e_d.rise_seen = 1'b1;
                if (e_q.cnt == BCW'(DATA_W - 1)) begin
                    byte_done = 1'b1;
                    if (e_q.first_pend) begin
                        first_done     = 1'b1;
                        e_d.first_pend = 1'b0;
                        if (cmd_mode) e_d.cmd = 1'b1;
                    end
                end
            end else if (ev.fall && e_q.rise_seen) begin
                e_d.rise_seen = 1'b0;
                if (e_q.cnt == '0) begin
                    if (fifo_dir_out && f_cnt != '0) begin
                        e_d.tx    = f_head;
                        shift_pop = 1'b1;
                    end else begin
                        e_d.tx = '1;
                    end
                end else begin
                    e_d.tx = {e_q.tx[DATA_W-2:0], 1'b1};
                end
            end
        end
        e_d.fif = first_done | (e_q.fif & ~first_if_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q        <= '0;
            e_q.preset <= PRESET_RST[DATA_W-1:0];
            e_q.tx     <= '1;
            e_q.cs_p   <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign f_push  = fifo_dir_out ? host_push : byte_done;
    assign f_pdata = fifo_dir_out ? host_wdata : rx_byte;
    assign f_pop   = fifo_dir_out ? shift_pop : host_pop;

    spis_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (f_push),
        .push_data (f_pdata),
        .pop       (f_pop),
        .head      (f_head),
        .count     (f_cnt)
    );

    assign host_rdata     = f_head;
    assign fifo_count     = f_cnt;
    assign miso_o         = e_q.tx[DATA_W-1];
    assign miso_oe        = slave_en & miso_oe_en & e_q.sel & (~two_wire | fifo_dir_out);
    assign st_selected    = e_q.sel;
    assign st_cmd_rcvd    = e_q.cmd;
    assign st_preset_load = e_q.load;
    assign first_if       = e_q.fif;
    assign irq            = e_q.fif & first_ie;

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (st_selected && miso_oe_en));
    p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_preset_load |=> !st_preset_load);
    p_cmd_needs_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_q.cmd) |-> $past(cmd_mode));
    p_desel_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_q.sel) |-> (e_q.cnt == '0 && !e_q.rise_seen));
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (first_if_clr && !first_done) |=> !first_if);
    p_disabled_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_en |=> !st_selected);
endmodule

// File: tb/tb_spi_preset_slave.sv
module tb_spi_preset_slave;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_en = 1'b1, cmd_mode = 1'b0, two_wire = 1'b0, miso_oe_en = 1'b1;
    logic       fifo_dir_out = 1'b0, first_ie = 1'b1, preset_we = 1'b0;
    logic [7:0] preset_wdata = 8'h00, host_wdata = 8'h00;
    logic       host_push = 1'b0, host_pop = 1'b0, first_if_clr = 1'b0;
    logic       sck_i = 1'b0, cs_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
    logic [7:0] host_rdata;
    logic [3:0] fifo_count;
    logic       miso_o, miso_oe, st_selected, st_cmd_rcvd, st_preset_load, first_if, irq;
    logic       mode3 = 1'b0;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    spi_preset_slave dut (
        .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .cmd_mode(cmd_mode),
        .two_wire(two_wire), .miso_oe_en(miso_oe_en), .fifo_dir_out(fifo_dir_out),
        .first_ie(first_ie), .preset_we(preset_we), .preset_wdata(preset_wdata),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
        .host_rdata(host_rdata), .fifo_count(fifo_count), .first_if_clr(first_if_clr),
        .sck_i(sck_i), .cs_n_i(cs_n_i), .mosi_i(mosi_i), .miso_i(miso_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .st_selected(st_selected),
        .st_cmd_rcvd(st_cmd_rcvd), .st_preset_load(st_preset_load),
        .first_if(first_if), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state
    logic       m_cs1, m_cs2, m_csp, m_sk1, m_sk2, m_skp, m_d1, m_d2;
    logic [7:0] m_preset, m_tx, m_rx;
    int         m_cnt;
    logic       m_seen, m_fp, m_sel, m_cmd, m_load, m_fif;
    logic [7:0] m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_cs1, m_cs2, m_csp} = 3'b111;
            {m_sk1, m_sk2, m_skp, m_d1, m_d2} = '0;
            m_preset = 8'h10; m_tx = 8'hFF; m_rx = 8'h00; m_cnt = 0;
            {m_seen, m_fp, m_sel, m_cmd, m_load, m_fif} = '0;
            m_q.delete();
        end else begin
            logic rise, fall, csf, csr, bd, fd, sp, push_ok, pop_ok;
            logic [7:0] nb;
            rise = m_sk2 && !m_skp; fall = !m_sk2 && m_skp;
            csf = !m_cs2 && m_csp;  csr = m_cs2 && !m_csp;
            push_ok = m_q.size() < 8; pop_ok = m_q.size() > 0;
            bd = 0; fd = 0; sp = 0; nb = {m_rx[6:0], m_d2};
            m_load = 0;
            if (!slave_en || csr) begin
                m_sel = 0; m_cnt = 0; m_seen = 0;
            end else if (csf) begin
                m_sel = 1; m_tx = m_preset; m_cnt = 0; m_seen = 0; m_fp = 1; m_load = 1; m_cmd = 0;
            end else if (m_sel) begin
                if (rise) begin
                    m_rx = nb; m_seen = 1;
                    if (m_cnt == 7) begin
                        bd = 1; m_cnt = 0;
                        if (m_fp) begin fd = 1; m_fp = 0; if (cmd_mode) m_cmd = 1; end
                    end else m_cnt++;
                end else if (fall && m_seen) begin
                    m_seen = 0;
                    if (m_cnt == 0) begin
                        if (fifo_dir_out && pop_ok) begin m_tx = m_q[0]; sp = 1; end
                        else m_tx = 8'hFF;
                    end else m_tx = {m_tx[6:0], 1'b1};
                end
            end
            if (preset_we) m_preset = preset_wdata;
            if (fifo_dir_out) begin
                if (sp) void'(m_q.pop_front());
                if (host_push && push_ok) m_q.push_back(host_wdata);
            end else begin
                if (host_pop && pop_ok) void'(m_q.pop_front());
                if (bd && push_ok) m_q.push_back(nb);
            end
            m_fif = fd || (m_fif && !first_if_clr);
            m_csp = m_cs2; m_cs2 = m_cs1; m_cs1 = cs_n_i;
            m_skp = m_sk2; m_sk2 = m_sk1; m_sk1 = sck_i;
            m_d2 = m_d1; m_d1 = two_wire ? miso_i : mosi_i;
            #(CLK_P/4);
            chk("R2 R4 R5 R6 miso_o", miso_o, m_tx[7]);
            chk("R10 miso_oe", miso_oe, slave_en && miso_oe_en && m_sel && (!two_wire || fifo_dir_out));
            chk("R7 R12 st_selected", st_selected, m_sel);
            chk("R7 st_preset_load", st_preset_load, m_load);
            chk("R8 st_cmd_rcvd", st_cmd_rcvd, m_cmd);
            chk("R9 first_if", first_if, m_fif);
            chk("R9 irq", irq, m_fif && first_ie);
            chk("R3 R11 fifo_count", fifo_count, m_q.size());
            if (m_q.size() > 0) chk("R3 host_rdata", host_rdata, m_q[0]);
        end
    end

    task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] got);
        got = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            if (mode3) sck_i = 1'b0;
            if (two_wire) miso_i = b[7-i]; else mosi_i = b[7-i];
            repeat (4) @(negedge clk);
            got = {got[6:0], miso_o};
            sck_i = 1'b1;
            repeat (4) @(negedge clk);
            if (!mode3) sck_i = 1'b0;
        end
    endtask

    task automatic sel_on();  cs_n_i = 1'b0; repeat (5) @(negedge clk); endtask
    task automatic sel_off(); cs_n_i = 1'b1; repeat (5) @(negedge clk); endtask
    task automatic push_b(input logic [7:0] v);
        host_wdata = v; host_push = 1'b1; @(negedge clk); host_push = 1'b0; @(negedge clk);
    endtask
    task automatic pop_chk(input string tag, input logic [7:0] exp);
        chk(tag, host_rdata, exp);
        host_pop = 1'b1; @(negedge clk); host_pop = 1'b0; @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [7:0] g;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count", fifo_count, 0);
        chk("R1 outputs", {miso_oe, st_selected, st_cmd_rcvd, st_preset_load, first_if, irq}, 0);
        chk("R1 miso idle", miso_o, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 push ignored in receive direction
        push_b(8'hEE);
        chk("R3 push ignored", fifo_count, 0);

        // R7 select latency, R2 default preset, R3 receive
        cs_n_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 not yet selected", st_selected, 0);
        @(negedge clk);
        chk("R7 selected", st_selected, 1);
        chk("R7 preset load", st_preset_load, 1);
        @(negedge clk);
        chk("R7 load pulse ends", st_preset_load, 0);
        xfer(8'hA5, 8, g); chk("R2 default preset reply", g, 8'h10);
        xfer(8'h3C, 8, g); chk("R4 filler reply", g, 8'hFF);
        sel_off();
        chk("R3 two bytes", fifo_count, 2);
        chk("R9 flag set", first_if, 1);
        chk("R9 irq", irq, 1);
        pop_chk("R3 first byte", 8'hA5);
        pop_chk("R3 second byte", 8'h3C);
        first_if_clr = 1'b1; @(negedge clk); first_if_clr = 1'b0; @(negedge clk);
        chk("R9 cleared", first_if, 0);

        // R5 mode 3, R8 command, R2 preset write
        preset_wdata = 8'h5A; preset_we = 1'b1; @(negedge clk); preset_we = 1'b0;
        cmd_mode = 1'b1; mode3 = 1'b1; sck_i = 1'b1; repeat (5) @(negedge clk);
        sel_on();
        xfer(8'h9E, 8, g); chk("R5 mode3 preset", g, 8'h5A);
        repeat (4) @(negedge clk);
        chk("R8 cmd set", st_cmd_rcvd, 1);
        sel_off();
        pop_chk("R8 cmd byte queued", 8'h9E);
        sel_on();
        chk("R8 cleared on select", st_cmd_rcvd, 0);
        sel_off();
        cmd_mode = 1'b0; mode3 = 1'b0; sck_i = 1'b0; repeat (5) @(negedge clk);
        first_if_clr = 1'b1; @(negedge clk); first_if_clr = 1'b0;

        // R4 reply from queue
        fifo_dir_out = 1'b1;
        push_b(8'h11); push_b(8'h22);
        host_pop = 1'b1; @(negedge clk); host_pop = 1'b0; @(negedge clk);
        chk("R4 pop ignored", fifo_count, 2);
        sel_on();
        chk("R10 oe driven", miso_oe, 1);
        xfer(8'h00, 8, g); chk("R4 preset", g, 8'h5A);
        xfer(8'h00, 8, g); chk("R4 queued 1", g, 8'h11);
        xfer(8'h00, 8, g); chk("R4 queued 2", g, 8'h22);
        xfer(8'h00, 8, g); chk("R4 empty filler", g, 8'hFF);
        sel_off();
        chk("R4 drained", fifo_count, 0);
        fifo_dir_out = 1'b0;

        // R6 partial byte discarded
        sel_on();
        xfer(8'hF0, 3, g);
        sel_off();
        sel_on();
        xfer(8'h77, 8, g); chk("R6 preset reloaded", g, 8'h5A);
        sel_off();
        chk("R6 one byte", fifo_count, 1);
        pop_chk("R6 clean byte", 8'h77);

        // R11 shared pin, R10 no drive in receive direction
        two_wire = 1'b1; mosi_i = 1'b0;
        sel_on();
        chk("R10 oe off", miso_oe, 0);
        xfer(8'hC3, 8, g);
        sel_off();
        two_wire = 1'b0; miso_i = 1'b0;
        pop_chk("R11 shared pin byte", 8'hC3);

        // R12 disabled
        slave_en = 1'b0;
        sel_on();
        chk("R12 not selected", st_selected, 0);
        xfer(8'h99, 8, g);
        sel_off();
        chk("R12 nothing queued", fifo_count, 0);
        slave_en = 1'b1; repeat (4) @(negedge clk);

        // R3 full queue drops
        sel_on();
        for (int i = 0; i < 9; i++) xfer(8'h30 + 8'(i), 8, g);
        sel_off();
        chk("R3 full", fifo_count, 8);
        chk("R3 oldest", host_rdata, 8'h30);

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule